// File: doc/BRIEF.md
# Ranked Candidate Best-Four Sorter

This block selects the four strongest of eight track candidates presented together in one clock cycle. Each candidate is a 22-bit word. A 7-bit rank inside the word decides its strength: a 5-bit momentum code sits above a 2-bit quality code. The four winners leave the block in descending rank order as one 88-bit bundle. Each output slot also carries the input position the winner came from and a flag that marks whether the slot holds a real candidate.

Upstream sources often fill only some of their slots, so a candidate whose rank is zero is treated as empty. An empty candidate never displaces a real one, and an output slot with nothing to show is driven as all zeros. All pairwise comparisons run in parallel. The block is registered with a fixed latency of two cycles and accepts a new set of eight candidates on every cycle. It is meant as the leaf unit of a larger sort tree.

Top module: `rank_best4_sorter`

## Requirements
- R1: During reset and in the first cycles after it, outValid is 0, every outSlotValid bit is 0, and outWords and outIdx are all zeros.
- R2: When inValid is high on a clock edge, outValid is high exactly two edges later. A new candidate set can be accepted on every consecutive cycle.
- R3: The rank of a candidate is word bits [21:15]: momentum in [21:17] above quality in [16:15]. A higher rank is placed in a lower-numbered output slot, so momentum outweighs quality.
- R4: A selected candidate appears in its output slot with all 22 bits unchanged. Slot k occupies outWords[22k+21:22k].
- R5: Candidates with equal rank are ordered by input position: the lower input number takes the lower output slot.
- R6: A candidate with rank zero is empty. Empty candidates are never selected. Slots left without a candidate have outSlotValid low, a zero word and a zero index, and always follow every filled slot.
- R7: outIdx[3k+2:3k] gives the input position (0 to 7) of the candidate in slot k, where input i occupies inWords[22i+21:22i].
- R8: A result that follows a cycle with inValid low has outValid low and all slots empty, whatever the candidate words were.
- R9: Only the four highest-ranked non-empty candidates are output. Every lower-ranked candidate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Marks the candidate set on inWords as present |
| inWords | input | 176 | Eight 22-bit candidates, input i at [22i+21:22i] |
| outValid | output | 1 | Marks the sorted result as present |
| outWords | output | 88 | Four 22-bit winners, slot 0 holds the highest rank |
| outIdx | output | 12 | 3-bit input position for each slot |
| outSlotValid | output | 4 | Per-slot flag, set when the slot holds a candidate |

## Verification
The hardest situation to bring about from the ports is a set that mixes ties and empty slots. Several candidates share a rank across the boundary between the fourth and fifth place, and some of the other inputs are empty but carry nonzero payload bits below the rank field. In that case only the tie order and the empty rule decide which words survive. To reach it, the random stimulus often draws momentum from a narrow range of four values and makes about a quarter of the candidates empty with random low bits. Directed sets cover all-equal ranks, a momentum-against-quality contest, a lone candidate on the last input, and a cycle with inValid low. The test also includes back-to-back valid cycles.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  localparam int CAND_W  = 22;
  localparam int NUM_IN  = 8;
  localparam int NUM_OUT = 4;
  localparam int KEY_HI  = 21;  // momentum code top bit
  localparam int KEY_LO  = 15;  // quality code bottom bit

  typedef struct packed {
    logic capture;  // latch a new candidate set into stage one
    logic emit;     // stage two publishes a sorted result
  } sort_strobe_t;
endpackage

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output sort_strobe_t strobe,
  output logic         outValid
);
  logic stageOneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageOneValid <= 1'b0;
      outValid      <= 1'b0;
    end else begin
      stageOneValid <= inValid;
      outValid      <= stageOneValid;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.emit    = stageOneValid;
  end

  // R2: a filled stage one always produces a result on the next edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    stageOneValid |=> outValid);
  // R8: no result without a filled stage one before it
  a_r8_valid_source: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stageOneValid));
endmodule

// File: rtl/sort_dpath.sv
module sort_dpath
  import sorter_pkg::*;
#(
  parameter int NumIn  = NUM_IN,
  parameter int NumOut = NUM_OUT,
  parameter int CandW  = CAND_W,
  parameter int KeyHi  = KEY_HI,
  parameter int KeyLo  = KEY_LO
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  sort_strobe_t                    strobe,
  input  logic [NumIn*CandW-1:0]          inWords,
  output logic [NumOut*CandW-1:0]         outWords,
  output logic [NumOut*$clog2(NumIn)-1:0] outIdx,
  output logic [NumOut-1:0]               outSlotValid
);
  localparam int KeyW = KeyHi - KeyLo + 1;
  localparam int IdxW = $clog2(NumIn);

  // stage one: pairwise comparisons on the incoming set
  logic [CandW-1:0]  inCand   [NumIn];
  logic [NumIn-1:0]  beatNext [NumIn];  // row i: inputs that i outranks
  logic [CandW-1:0]  s1Cand   [NumIn];
  logic [NumIn-1:0]  s1Beat   [NumIn];

  for (genvar i = 0; i < NumIn; i++) begin : g_unpack
    assign inCand[i] = inWords[i*CandW +: CandW];
  end

  for (genvar i = 0; i < NumIn; i++) begin : g_row
    for (genvar j = 0; j < NumIn; j++) begin : g_col
      if (i == j) begin : g_self
        assign beatNext[i][j] = 1'b0;
      end else if (i < j) begin : g_lower
        assign beatNext[i][j] = inCand[i][KeyHi:KeyLo] >= inCand[j][KeyHi:KeyLo];
      end else begin : g_upper
        assign beatNext[i][j] = inCand[i][KeyHi:KeyLo] > inCand[j][KeyHi:KeyLo];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NumIn; i++) begin
      if (!rstN) begin
        s1Cand[i] <= '0;
        s1Beat[i] <= '0;
      end else if (strobe.capture) begin
        s1Cand[i] <= inCand[i];
        s1Beat[i] <= beatNext[i];
      end
    end
  end

  // stage two: rank position by counting who outranks each candidate
  logic [NumIn-1:0]  beatenBy [NumIn];
  logic [IdxW-1:0]   rankPos  [NumIn];
  logic [NumIn-1:0]  slotHit  [NumOut];
  logic [CandW-1:0]  selWord  [NumOut];
  logic [IdxW-1:0]   selIdx   [NumOut];

  always_comb begin
    for (int i = 0; i < NumIn; i++) begin
      for (int j = 0; j < NumIn; j++) beatenBy[i][j] = s1Beat[j][i];
      rankPos[i] = IdxW'($countones(beatenBy[i]));
    end
  end

  for (genvar k = 0; k < NumOut; k++) begin : g_slot
    for (genvar i = 0; i < NumIn; i++) begin : g_pick
      assign slotHit[k][i] = (rankPos[i] == IdxW'(k)) &&
                             (s1Cand[i][KeyHi:KeyLo] != '0);
    end
    always_comb begin
      selWord[k] = '0;
      selIdx[k]  = '0;
      for (int i = 0; i < NumIn; i++) begin
        if (slotHit[k][i]) begin
          selWord[k] = selWord[k] | s1Cand[i];
          selIdx[k]  = selIdx[k]  | IdxW'(i);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || !strobe.emit) begin
        outWords[k*CandW +: CandW] <= '0;
        outIdx[k*IdxW +: IdxW]     <= '0;
        outSlotValid[k]            <= 1'b0;
      end else begin
        outWords[k*CandW +: CandW] <= selWord[k];
        outIdx[k*IdxW +: IdxW]     <= selIdx[k];
        outSlotValid[k]            <= |slotHit[k];
      end
    end

    // R9: at most one candidate claims each output slot
    a_r9_single_claim: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(slotHit[k]));
    // R6: an empty slot carries nothing
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
      !outSlotValid[k] |-> (outWords[k*CandW +: CandW] == '0 &&
                            outIdx[k*IdxW +: IdxW] == '0));

    if (k > 0) begin : g_pair
      // R6: filled slots are packed toward slot zero
      a_r6_packed: assert property (@(posedge clk) disable iff (!rstN)
        outSlotValid[k] |-> outSlotValid[k-1]);
      // R3: rank never rises from one slot to the next
      a_r3_descending: assert property (@(posedge clk) disable iff (!rstN)
        outSlotValid[k] |-> (outWords[(k-1)*CandW+KeyLo +: KeyW] >=
                             outWords[k*CandW+KeyLo +: KeyW]));
      // R5: equal ranks keep input order
      a_r5_tie_order: assert property (@(posedge clk) disable iff (!rstN)
        (outSlotValid[k] && outWords[(k-1)*CandW+KeyLo +: KeyW] ==
                            outWords[k*CandW+KeyLo +: KeyW])
        |-> (outIdx[(k-1)*IdxW +: IdxW] < outIdx[k*IdxW +: IdxW]));
    end

    for (genvar m = 0; m < k; m++) begin : g_dist
      // R7: no input position is reported twice
      a_r7_distinct_idx: assert property (@(posedge clk) disable iff (!rstN)
        (outSlotValid[k] && outSlotValid[m]) |->
        (outIdx[k*IdxW +: IdxW] != outIdx[m*IdxW +: IdxW]));
    end
  end
endmodule

// File: rtl/rank_best4_sorter.sv
module rank_best4_sorter
  import sorter_pkg::*;
#(
  parameter int NumIn  = NUM_IN,
  parameter int NumOut = NUM_OUT,
  parameter int CandW  = CAND_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [NumIn*CandW-1:0]          inWords,
  output logic                            outValid,
  output logic [NumOut*CandW-1:0]         outWords,
  output logic [NumOut*$clog2(NumIn)-1:0] outIdx,
  output logic [NumOut-1:0]               outSlotValid
);
  sort_strobe_t strobe;

  sort_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sort_dpath #(
    .NumIn  (NumIn),
    .NumOut (NumOut),
    .CandW  (CandW),
    .KeyHi  (KEY_HI),
    .KeyLo  (KEY_LO)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inWords      (inWords),
    .outWords     (outWords),
    .outIdx       (outIdx),
    .outSlotValid (outSlotValid)
  );
endmodule

// File: tb/rank_best4_sorter_tb.sv
module rank_best4_sorter_tb_top;
  localparam int ClkPeriod = 10;
  localparam int ResW = 1 + 4 + 12 + 88;  // valid, slot flags, indices, words

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [175:0] inWords = '0;
  logic         outValid;
  logic [87:0]  outWords;
  logic [11:0]  outIdx;
  logic [3:0]   outSlotValid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [ResW-1:0] exp1 = '0, exp2 = '0;
  string tag1 = "R8", tag2 = "R8";

  always #(ClkPeriod/2) clk = ~clk;

  rank_best4_sorter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWords(inWords),
    .outValid(outValid), .outWords(outWords), .outIdx(outIdx),
    .outSlotValid(outSlotValid)
  );

  function automatic logic [21:0] mk(int pt, int q, int low);
    return {5'(pt), 2'(q), 15'(low)};
  endfunction

  // independent model: repeated selection of the strongest unused entry
  function automatic logic [ResW-1:0] model(logic v, logic [175:0] w);
    logic [87:0] ow = '0;
    logic [11:0] oi = '0;
    logic [3:0]  ov = '0;
    bit used [8];
    for (int i = 0; i < 8; i++) used[i] = 0;
    if (!v) return '0;
    for (int k = 0; k < 4; k++) begin
      int best = -1;
      int bestKey = 0;
      for (int i = 0; i < 8; i++) begin
        int key = int'(w[22*i+15 +: 7]);
        if (!used[i] && key > bestKey) begin
          best = i;
          bestKey = key;
        end
      end
      if (best >= 0) begin
        used[best] = 1;
        ov[k] = 1'b1;
        oi[3*k +: 3] = 3'(best);
        ow[22*k +: 22] = w[22*best +: 22];
      end
    end
    return {1'b1, ov, oi, ow};
  endfunction

  task automatic chk(string req, string what, logic [87:0] act, logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: check the result due now, then present a new set
  task automatic step(logic v, logic [175:0] w, string tag);
    @(negedge clk);
    chk("R2", "outValid", 88'(outValid), 88'(exp2[ResW-1]));
    chk("R6", "slot flags", 88'(outSlotValid), 88'(exp2[103:100]));
    chk("R7", "indices", 88'(outIdx), 88'(exp2[99:88]));
    chk(tag2, "words", outWords, exp2[87:0]);
    exp2 = exp1;
    tag2 = tag1;
    exp1 = model(v, w);
    tag1 = tag;
    inValid = v;
    inWords = w;
  endtask

  function automatic logic [21:0] randCand();
    int pt, q;
    if ($urandom_range(3) == 0) return {7'd0, 15'($urandom)};
    pt = ($urandom_range(1) == 0) ? $urandom_range(3) + 8 : $urandom_range(31);
    q  = $urandom_range(3);
    return mk(pt, q, $urandom);
  endfunction

  initial begin
    logic [175:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "reset valid", 88'(outValid), 88'd0);
    chk("R1", "reset slots", 88'(outSlotValid), 88'd0);
    chk("R1", "reset words", outWords, 88'd0);
    chk("R1", "reset idx", 88'(outIdx), 88'd0);
    rstN = 1'b1;

    // R6: every input empty, payload bits set below the rank field
    for (int i = 0; i < 8; i++) w[22*i +: 22] = mk(0, 0, 32'h7abc + i);
    step(1'b1, w, "R6");
    // R5: all ranks equal, lower inputs win
    for (int i = 0; i < 8; i++) w[22*i +: 22] = mk(9, 2, i * 17);
    step(1'b1, w, "R5");
    // R9: ranks rise with input number, top four from inputs 7..4
    for (int i = 0; i < 8; i++) w[22*i +: 22] = mk(3 * i + 1, i % 4, i);
    step(1'b1, w, "R9");
    // R3: momentum outweighs quality
    w = '0;
    w[0 +: 22]  = mk(1, 3, 5);
    w[22 +: 22] = mk(2, 0, 6);
    w[44 +: 22] = mk(1, 2, 7);
    step(1'b1, w, "R3");
    // R7: a lone candidate on the last input
    w = '0;
    w[154 +: 22] = mk(31, 3, 15'h7fff);
    step(1'b1, w, "R7");
    // R8: full set presented with inValid low
    for (int i = 0; i < 8; i++) w[22*i +: 22] = mk(20, 1, i);
    step(1'b0, w, "R8");
    // R4: random sets, back to back, occasional gaps
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < 8; i++) w[22*i +: 22] = randCand();
      step($urandom_range(9) != 0, w, "R4");
    end
    step(1'b0, '0, "R8");
    step(1'b0, '0, "R8");
    step(1'b0, '0, "R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule